// File: doc/BRIEF.md
# Memory Bandwidth Throttle Filter

This block watches the weighted traffic presented to the memory bus and decides, clock by clock, whether new transactions may start. Each cycle it takes a weight, adds it to a first-order exponential averaging filter, and compares the filtered per-clock value against a limit. When the filtered value is at or above that limit, a registered stall output tells the issuing logic to hold back.

Two 8-bit limits exist. The bandwidth limit is in force during ordinary bandwidth-based throttling. The thermal limit takes over whenever the thermal throttle request input is high. A three-bit code sets how slowly the filter responds, and its shift amount is `SHIFT_BASE` plus zero to three. At the default `SHIFT_BASE` of 28 the time constant ranges from 2^28 to 2^31 clocks. A small configuration port holds the code, both limits and a lock bit. Once the lock bit is set, the settings can no longer be changed.

Top module: `bwgate_top`

## Requirements
- R1: After a synchronous active-low reset, the time-constant code, both limits and the lock bit read back as zero, the filtered value is zero, and stall is low.
- R2: Configuration addresses are 0 for the time-constant code (bits 2:0 of the data, upper bits read zero), 1 for the bandwidth limit, 2 for the thermal limit and 3 for the lock (bit 0). A write takes effect at the clock edge where `cfg_we` is high. `cfg_rdata` shows the addressed register combinationally.
- R3: At each clock the accumulator becomes acc + weight - (acc >> s), where s = `SHIFT_BASE` + code. `avg_out` equals acc >> s for the current register values.
- R4: Codes 4 to 7 act exactly like code 0 in the filter, while reading back unchanged.
- R5: When `thermal_req` is low, stall after a clock edge is 1 exactly when the filtered value before that edge was greater than or equal to the bandwidth limit.
- R6: When `thermal_req` is high, the same comparison uses the thermal limit instead.
- R7: Stall is registered and lags the accumulator by one clock. With both limits at zero, stall is high from the first clock after reset is released.
- R8: Writing 1 to lock bit 0 sets the lock. Writing 0 never clears it. Only reset clears it.
- R9: While locked, writes to the time-constant code and to both limits change neither their read-back nor the filter or stall behaviour.
- R10: The accumulator never wraps. It stays at or below (2^IN_W - 1) << (`SHIFT_BASE` + 3) under a continuous maximum weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wt_in | input | IN_W | Weighted transaction count for this clock |
| thermal_req | input | 1 | Selects the thermal limit when high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read-back of the addressed register |
| avg_out | output | IN_W+4 | Filtered per-clock value (acc >> s) |
| stall | output | 1 | High: no new transaction may start |

## Verification
Two functions can fall in the same cycle: a configuration write that changes a limit or the code, and the filter/compare step that uses the old register values on that same edge. The bench issues writes while traffic is flowing and `thermal_req` is toggling. A cycle-accurate predictor applies each write only after that cycle's compare and filter step, so every stall and `avg_out` sample in those cycles is judged against the register values held before the edge. Locked writes arrive mid-stream in the same way and must leave the predicted sequence unchanged.

// File: rtl/bwgate_pkg.sv
// Package: shared address encoding and time-constant decode for the
// bandwidth throttle filter. Assumes a 3-bit time-constant code.
package bwgate_pkg;
    localparam int TC_W = 3;

    typedef enum logic [1:0] {
        CFG_TC    = 2'd0,
        CFG_BWLIM = 2'd1,
        CFG_THLIM = 2'd2,
        CFG_LOCK  = 2'd3
    } cfg_addr_e;

    // Maps a time-constant code to a shift offset; codes 4..7 fold to 0.
    function automatic logic [1:0] tc_offset(input logic [TC_W-1:0] code);
        return code[2] ? 2'd0 : code[1:0];
    endfunction
endpackage

// File: rtl/bwgate_regs.sv
// Configuration registers: time-constant code, two limits and a sticky lock.
// Assumes cfg_wdata is at least LIM_W bits wide; the read path is combinational.
module bwgate_regs
    import bwgate_pkg::*;
#(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [LIM_W-1:0] cfg_wdata,
    output logic [LIM_W-1:0] cfg_rdata,
    output logic [TC_W-1:0]  tc_q,
    output logic [LIM_W-1:0] bw_lim_q,
    output logic [LIM_W-1:0] th_lim_q,
    output logic             locked_q
);
    localparam int PAD_TC = LIM_W - TC_W;

    cfg_addr_e addr;
    logic      wr_ok;

    assign addr  = cfg_addr_e'(cfg_addr);
    assign wr_ok = cfg_we && !locked_q;

    // Register update: writes land only while unlocked; lock can only be set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q     <= '0;
            bw_lim_q <= '0;
            th_lim_q <= '0;
            locked_q <= 1'b0;
        end else if (wr_ok) begin
            case (addr)
                CFG_TC:    tc_q     <= cfg_wdata[TC_W-1:0];
                CFG_BWLIM: bw_lim_q <= cfg_wdata;
                CFG_THLIM: th_lim_q <= cfg_wdata;
                CFG_LOCK:  locked_q <= cfg_wdata[0];
                default:   ;
            endcase
        end
    end

    // Read mux: shows the addressed register with zero padding.
    always_comb begin
        case (addr)
            CFG_TC:    cfg_rdata = {{PAD_TC{1'b0}}, tc_q};
            CFG_BWLIM: cfg_rdata = bw_lim_q;
            CFG_THLIM: cfg_rdata = th_lim_q;
            default:   cfg_rdata = {{(LIM_W-1){1'b0}}, locked_q};
        endcase
    end

    // R8: once set, the lock stays set until reset.
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> locked_q);

    // R9: a write while locked leaves every setting unchanged.
    a_r9_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && cfg_we) |=> ($stable(tc_q) && $stable(bw_lim_q) && $stable(th_lim_q)));
endmodule

// File: rtl/bwgate_filter.sv
// First-order exponential averaging filter: acc += in - (acc >> s).
// Assumes ACC_W is wide enough that the steady-state value in << s_max fits.
module bwgate_filter
    import bwgate_pkg::*;
#(
    parameter int IN_W       = 8,
    parameter int SHIFT_BASE = 28,
    parameter int ACC_W      = SHIFT_BASE + 3 + IN_W + 1,
    parameter int AVG_W      = ACC_W - SHIFT_BASE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  wt_in,
    input  logic [TC_W-1:0]  tc,
    output logic [AVG_W-1:0] avg
);
    localparam int SH_W = $clog2(SHIFT_BASE + 4) + 1;
    localparam logic [ACC_W-1:0] ACC_MAX =
        ACC_W'((2**IN_W) - 1) << (SHIFT_BASE + 3);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] leak;
    logic [SH_W-1:0]  shamt;

    assign shamt = SH_W'(SHIFT_BASE) + SH_W'(tc_offset(tc));
    assign leak  = acc_q >> shamt;
    assign avg   = AVG_W'(leak);

    // Accumulator step: add this clock's weight, drain one time-constant share.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + ACC_W'(wt_in) - leak;
    end

    // R10: the accumulator stays within its no-overflow bound.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= ACC_MAX);

    // R3: with no incoming weight the accumulator never grows.
    a_r3_idle_decay: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_in == '0) |=> (acc_q <= $past(acc_q)));
endmodule

// File: rtl/bwgate_cmp.sv
// Limit select and registered stall: stall <= (avg >= active limit).
// Assumes AVG_W >= LIM_W so the limit zero-extends without loss.
module bwgate_cmp #(
    parameter int LIM_W = 8,
    parameter int AVG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AVG_W-1:0] avg,
    input  logic [LIM_W-1:0] bw_lim,
    input  logic [LIM_W-1:0] th_lim,
    input  logic             thermal_req,
    output logic             stall
);
    logic [AVG_W-1:0] lim_ext;

    assign lim_ext = thermal_req ? AVG_W'(th_lim) : AVG_W'(bw_lim);

    // Stall register: one clock behind the filtered value it judges.
    always_ff @(posedge clk) begin
        if (!rst_n) stall <= 1'b0;
        else        stall <= (avg >= lim_ext);
    end

    // R1: reset leaves stall low.
    a_r1_reset_stall: assert property (@(posedge clk)
        !rst_n |=> !stall);

    // R5: in bandwidth mode stall follows the bandwidth limit.
    a_r5_bw_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(thermal_req)) |->
            (stall == ($past(avg) >= AVG_W'($past(bw_lim)))));

    // R6: in thermal mode stall follows the thermal limit.
    a_r6_th_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(thermal_req)) |->
            (stall == ($past(avg) >= AVG_W'($past(th_lim)))));
endmodule

// File: rtl/bwgate_top.sv
// Memory bandwidth throttle filter top: registers, averaging filter and
// registered limit compare. Assumes weights arrive one per clock.
module bwgate_top
    import bwgate_pkg::*;
#(
    parameter int IN_W       = 8,
    parameter int SHIFT_BASE = 28
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] wt_in,
    input  logic            thermal_req,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_addr,
    input  logic [7:0]      cfg_wdata,
    output logic [7:0]      cfg_rdata,
    output logic [IN_W+3:0] avg_out,
    output logic            stall
);
    localparam int LIM_W = 8;
    localparam int ACC_W = SHIFT_BASE + 3 + IN_W + 1;
    localparam int AVG_W = ACC_W - SHIFT_BASE;

    logic [TC_W-1:0]  tc_q;
    logic [LIM_W-1:0] bw_lim_q;
    logic [LIM_W-1:0] th_lim_q;
    logic             locked_q;
    logic [AVG_W-1:0] avg;

    bwgate_regs #(.LIM_W(LIM_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tc_q      (tc_q),
        .bw_lim_q  (bw_lim_q),
        .th_lim_q  (th_lim_q),
        .locked_q  (locked_q)
    );

    bwgate_filter #(
        .IN_W       (IN_W),
        .SHIFT_BASE (SHIFT_BASE),
        .ACC_W      (ACC_W),
        .AVG_W      (AVG_W)
    ) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .wt_in (wt_in),
        .tc    (tc_q),
        .avg   (avg)
    );

    bwgate_cmp #(.LIM_W(LIM_W), .AVG_W(AVG_W)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .avg         (avg),
        .bw_lim      (bw_lim_q),
        .th_lim      (th_lim_q),
        .thermal_req (thermal_req),
        .stall       (stall)
    );

    assign avg_out = avg;

    // R8: an unlocked block ignores a lock write of 0.
    a_r8_zero_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_q && cfg_we && cfg_addr == 2'd3 && !cfg_wdata[0]) |=> !locked_q);
endmodule

// File: tb/bwgate_top_bench.sv
// Scoreboard bench: a predictor pushes expected stall/avg per clock into
// queues and a monitor pops and compares them at the falling edge.
module bwgate_top_bench;
    localparam int SB = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wt_in = '0;
    logic       thermal_req = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [11:0] avg_out;
    logic       stall;

    always #5 clk = ~clk;

    bwgate_top #(.IN_W(8), .SHIFT_BASE(SB)) u_bwgate_top (
        .clk(clk), .rst_n(rst_n), .wt_in(wt_in), .thermal_req(thermal_req),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .avg_out(avg_out), .stall(stall)
    );

    int checks = 0;
    int fails  = 0;
    string a_tag = "R3";
    string s_tag = "R5 R7";
    int exp_stall_q[$];
    int exp_avg_q[$];

    // Predictor state
    int    m_tc = 0, m_bw = 0, m_th = 0, m_lock = 0, m_stall = 0;
    longint m_acc = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int shift_of(int code);
        return SB + ((code >= 4) ? 0 : code);
    endfunction

    // Monitor then predictor at each falling edge.
    always @(negedge clk) begin
        #1;
        if (exp_stall_q.size() > 0) begin
            check(s_tag, {31'b0, stall}, exp_stall_q.pop_front());
            check(a_tag, {20'b0, avg_out}, exp_avg_q.pop_front());
        end
        if (!rst_n) begin
            m_tc = 0; m_bw = 0; m_th = 0; m_lock = 0; m_stall = 0; m_acc = 0;
        end else begin
            int sh;
            int lim;
            sh = shift_of(m_tc);
            lim = thermal_req ? m_th : m_bw;
            m_stall = ((m_acc >> sh) >= lim) ? 1 : 0;
            m_acc = m_acc + wt_in - (m_acc >> sh);
            if (cfg_we && m_lock == 0) begin
                case (cfg_addr)
                    2'd0: m_tc = int'(cfg_wdata[2:0]);
                    2'd1: m_bw = int'(cfg_wdata);
                    2'd2: m_th = int'(cfg_wdata);
                    default: m_lock = int'(cfg_wdata[0]);
                endcase
            end
        end
        exp_stall_q.push_back(m_stall);
        exp_avg_q.push_back(int'(m_acc >> shift_of(m_tc)));
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, int exp, string req);
        cfg_addr = a;
        #1;
        check(req, {24'b0, cfg_rdata}, exp);
    endtask

    task automatic run(int n, int w);
        wt_in = 8'(w);
        step(n);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state of registers and outputs
        step(3);
        rd(2'd0, 0, "R1"); rd(2'd1, 0, "R1"); rd(2'd2, 0, "R1"); rd(2'd3, 0, "R1");
        check("R1", {31'b0, stall}, 0);
        check("R1", {20'b0, avg_out}, 0);
        rst_n = 1'b1;
        // R7: limits at zero, stall rises one clock after release
        step(3);
        check("R7", {31'b0, stall}, 1);

        // R2: register map and read-back
        wr(2'd0, 8'hFD); rd(2'd0, 5, "R2");
        wr(2'd0, 8'h01); rd(2'd0, 1, "R2");
        wr(2'd1, 8'd40); rd(2'd1, 40, "R2");
        wr(2'd2, 8'd10); rd(2'd2, 10, "R2");

        // R3 R5: bandwidth mode under several weight patterns
        s_tag = "R5 R7";
        run(60, 50);
        run(60, 0);
        for (int i = 0; i < 30; i++) begin run(1, 200); run(1, 0); end
        // limit change while traffic flows (same-cycle write and compare)
        wt_in = 8'd38;
        wr(2'd1, 8'd35);
        run(40, 38);

        // R6: thermal limit in force
        s_tag = "R6 R7";
        thermal_req = 1'b1;
        run(60, 20);
        s_tag = "R5 R6";
        for (int i = 0; i < 9; i++) begin
            thermal_req = ~thermal_req;
            run(7, 25);
        end
        thermal_req = 1'b0;

        // R4: reserved code behaves as code 0
        a_tag = "R4";
        wr(2'd0, 8'd6); rd(2'd0, 6, "R4");
        run(60, 30);
        run(30, 0);

        // R10: long maximum weight at the slowest time constant
        a_tag = "R10";
        wr(2'd0, 8'd3);
        run(300, 255);
        run(20, 60);

        // R8: lock set, zero write ignored
        a_tag = "R3";
        wr(2'd3, 8'd0); rd(2'd3, 0, "R8");
        wr(2'd3, 8'd1); rd(2'd3, 1, "R8");
        wr(2'd3, 8'd0); rd(2'd3, 1, "R8");

        // R9: locked writes ignored, mid-stream
        a_tag = "R9"; s_tag = "R9";
        wt_in = 8'd45;
        wr(2'd0, 8'd2); rd(2'd0, 3, "R9");
        wr(2'd1, 8'd99); rd(2'd1, 35, "R9");
        wr(2'd2, 8'd1); rd(2'd2, 10, "R9");
        run(30, 45);

        // R8: only reset clears the lock
        rst_n = 1'b0;
        step(2);
        rd(2'd3, 0, "R8");
        rd(2'd1, 0, "R1");
        rst_n = 1'b1;
        step(4);

        summary();
        $finish;
    end
endmodule